// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Access Unit

This unit sits in the serial datapath of a T1 line interface. On the receive side it watches a 24-frame extended superframe. It picks out the signaling bits that the line robs from the least significant bit of every channel in four frames of each superframe. It keeps them in twelve byte-wide receive registers that a simple processor bus can read. The received stream is forwarded to a serial output one bit-clock later. A single control input chooses what appears at the robbed positions on that output: the received values, or constant ones.

On the transmit side, twelve processor-writable byte registers hold the outgoing A, B, C and D bits for all 24 channels. The unit replaces the robbed positions of the outgoing stream with those bits and forwards everything else one bit-clock later. Frame, channel and bit position come from an external aligner through three index inputs. The unit does no framing of its own.

Position and bit conventions:
- Frames are numbered 0 to 23 and channels 0 to 23.
- Within a channel slot, bit index 0 is the first bit on the line and is the channel's most significant bit. Bit index 7 is the last bit and the least significant bit.
- The robbed positions are bit index 7 of every channel in frames 5, 11, 17 and 23. These carry the A, B, C and D bits in that order.

Top module: `t1_sig_access`

## Requirements
- R1: Register k (0 to 11) holds the signaling of channels 2k and 2k+1. Channel 2k occupies bits 7..4 and channel 2k+1 occupies bits 3..0. Within each nibble the order from the top bit down is A, B, C, D. Receive register k is read at address k, and transmit register k is read and written at address 16+k.
- R2: When the force input is 0, or at any non-robbed position, the receive output equals the receive data input sampled one clock earlier.
- R3: When the force input is 1, the receive output is 1 one clock after each robbed position has been sampled.
- R4: A receive register changes only at the clock edge that samples the last bit of channel 23 in a signaling frame. At that edge, the signaling letter of that frame is updated for all 24 channels at once. A read taken partway through a signaling frame therefore returns the previous values.
- R5: At a robbed position, the transmit output one clock later is the matching bit of the active transmit signaling set.
- R6: At every non-robbed position, the transmit output equals the transmit data input sampled one clock earlier.
- R7: A processor write to a transmit register reaches the line only from the next superframe. The active set is loaded from the written values at the edge that samples frame 23, channel 23, bit 7.
- R8: Writes to receive addresses (0 to 11) have no effect. Reads from addresses whose low four bits are 12 to 15 return 0.
- R9: After reset, both serial outputs are 0 and all 24 registers read 0.
- R10: A transmit register reads back the value last written to it, starting from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_num | input | 5 | Frame index within superframe, 0 to 23 |
| chan_idx | input | 5 | Channel index within frame, 0 to 23 |
| bit_idx | input | 3 | Bit index within channel, 0 first (MSB) to 7 last (LSB) |
| rx_data | input | 1 | Received serial data |
| force_ones | input | 1 | 1 forces robbed positions to 1 on rx_out |
| rx_out | output | 1 | Received serial data, one clock later |
| tx_in | input | 1 | Outgoing serial data before signaling insertion |
| tx_out | output | 1 | Outgoing serial data with signaling inserted, one clock later |
| cpu_addr | input | 5 | Register address: 0..11 receive, 16..27 transmit |
| cpu_wr | input | 1 | Write strobe, sampled on the clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from cpu_addr |

## Verification
The hardest situation to reach is a processor access that lands inside a signaling frame, while part of the robbed bits of that frame have been sampled and part have not. The bench drives complete superframes bit by bit from its own position counters. It reads every receive register halfway through each signaling frame, where the old letter must still show, and again at the start of the following frame, where the new letter must show. In the superframe that runs with forcing enabled, it writes a transmit register at the start of a signaling frame. It then checks every robbed bit for the rest of that superframe against the old set, and in the next superframe against the new one.

// File: rtl/t1_sig_access.sv
module t1_sig_access #(
  parameter int NCH = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] frame_num,
  input  logic [4:0] chan_idx,
  input  logic [2:0] bit_idx,
  input  logic       rx_data,
  input  logic       force_ones,
  output logic       rx_out,
  input  logic       tx_in,
  output logic       tx_out,
  input  logic [4:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata
);
  localparam int NREG = NCH / 2;
  localparam int NBIT = NREG * 8;

  logic            sig_frame;
  logic [1:0]      letter;
  logic            sig_pos, frame_end, sf_end, addr_ok;
  logic [NCH-1:0]  stage;
  logic [3:0][NCH-1:0] rx_sig;
  logic [NBIT-1:0] rx_img, tx_shd, tx_act;
  logic [6:0]      ins_idx, reg_base;

  always_comb begin
    sig_frame = 1'b1;
    letter    = 2'd0;
    case (frame_num)
      5'd5:  letter = 2'd0;
      5'd11: letter = 2'd1;
      5'd17: letter = 2'd2;
      5'd23: letter = 2'd3;
      default: sig_frame = 1'b0;
    endcase
  end

  assign sig_pos   = sig_frame && bit_idx == 3'd7 && chan_idx < 5'(NCH);
  assign frame_end = chan_idx == 5'(NCH - 1) && bit_idx == 3'd7;
  assign sf_end    = frame_end && frame_num == 5'd23;
  assign ins_idx   = {chan_idx[4:1], ~chan_idx[0], ~letter};
  assign reg_base  = {cpu_addr[3:0], 3'b000};
  assign addr_ok   = cpu_addr[3:0] < 4'(NREG);

  for (genvar k = 0; k < NREG; k++) begin : g_img
    for (genvar l = 0; l < 4; l++) begin : g_let
      assign rx_img[k*8 + 7 - l] = rx_sig[l][2*k];
      assign rx_img[k*8 + 3 - l] = rx_sig[l][2*k+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= '0;
      rx_sig <= '0;
    end else if (sig_pos) begin
      stage[chan_idx] <= rx_data;
      if (frame_end)
        rx_sig[letter] <= {rx_data, stage[NCH-2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_shd <= '0;
      tx_act <= '0;
    end else begin
      if (cpu_wr && cpu_addr[4] && addr_ok)
        tx_shd[reg_base +: 8] <= cpu_wdata;
      if (sf_end)
        tx_act <= tx_shd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out <= 1'b0;
      tx_out <= 1'b0;
    end else begin
      rx_out <= (sig_pos && force_ones) ? 1'b1 : rx_data;
      tx_out <= sig_pos ? tx_act[ins_idx] : tx_in;
    end
  end

  assign cpu_rdata = !addr_ok     ? 8'h00 :
                     cpu_addr[4]  ? tx_shd[reg_base +: 8] :
                                    rx_img[reg_base +: 8];
endmodule

module t1_sig_access_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  frame_num,
  input logic [4:0]  chan_idx,
  input logic [2:0]  bit_idx,
  input logic        rx_data,
  input logic        tx_in,
  input logic        force_ones,
  input logic        rx_out,
  input logic        tx_out,
  input logic [95:0] rx_regs,
  input logic [95:0] tx_set
);
  logic robbed, last_bit, last_sf;
  assign robbed   = (frame_num == 5'd5 || frame_num == 5'd11 || frame_num == 5'd17 ||
                     frame_num == 5'd23) && bit_idx == 3'd7 && chan_idx < 5'd24;
  assign last_bit = chan_idx == 5'd23 && bit_idx == 3'd7;
  assign last_sf  = last_bit && frame_num == 5'd23;

  // R2
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(robbed && force_ones) |=> rx_out == $past(rx_data));
  // R3
  rx_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (robbed && force_ones) |=> rx_out);
  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_bit |=> $stable(rx_regs));
  // R6
  tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !robbed |=> tx_out == $past(tx_in));
  // R7
  tx_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_sf |=> $stable(tx_set));
endmodule

bind t1_sig_access t1_sig_access_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_num(frame_num), .chan_idx(chan_idx),
  .bit_idx(bit_idx), .rx_data(rx_data), .tx_in(tx_in), .force_ones(force_ones),
  .rx_out(rx_out), .tx_out(tx_out), .rx_regs(rx_img), .tx_set(tx_act)
);

// File: tb/t1_sig_access_tb.sv
`timescale 1ns/10ps
module t1_sig_access_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] frame_num = '0, chan_idx = '0;
  logic [2:0] bit_idx = '0;
  logic rx_data = 1'b0, force_ones = 1'b0, tx_in = 1'b0;
  logic rx_out, tx_out;
  logic [4:0] cpu_addr = '0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit exp_rx [24][4];
  logic [7:0] shd [12];
  logic [7:0] act [12];

  always #10 clk = ~clk;

  t1_sig_access dut_i (.*);

  function automatic bit sv(int s, int c, int l);
    return ((c * 5 + l * 11 + s * 3) % 7) < 3;
  endfunction

  function automatic bit db(int s, int f, int c, int b);
    return (((f * 192 + c * 8 + b + s * 17) * 37) % 11) > 5;
  endfunction

  // R1 mapping: channel 2k -> bits 7..4, 2k+1 -> bits 3..0, A highest
  function automatic int bpos(int c, int l);
    return (c % 2 == 0) ? 7 - l : 3 - l;
  endfunction

  task automatic chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, a, e);
    end
  endtask

  task automatic rd_chk(input int addr, input logic [7:0] e, input string tag);
    cpu_addr = 5'(addr);
    #0.2;
    chk(cpu_rdata, e, tag);
  endtask

  task automatic chk_rx_regs(input string tag);
    for (int k = 0; k < 12; k++) begin
      logic [7:0] e = '0;
      for (int l = 0; l < 4; l++) begin
        e[bpos(2*k, l)]   = exp_rx[2*k][l];
        e[bpos(2*k+1, l)] = exp_rx[2*k+1][l];
      end
      rd_chk(k, e, tag);
    end
  endtask

  task automatic cpu_write(input int addr, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = 5'(addr); cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk); @(negedge clk);
    chk(8'(rx_out), 8'h0, "R9 rx_out");
    chk(8'(tx_out), 8'h0, "R9 tx_out");
    for (int k = 0; k < 12; k++) begin
      rd_chk(k, 8'h0, "R9 rx reg");
      rd_chk(16 + k, 8'h0, "R9 tx reg");
    end
    rst_n = 1'b1;
  endtask

  task automatic test_cpu_access();
    for (int k = 0; k < 12; k++) begin
      shd[k] = 8'(k * 29 + 53);
      cpu_write(16 + k, shd[k]);
    end
    for (int k = 0; k < 12; k++) rd_chk(16 + k, shd[k], "R10 tx readback");
    cpu_write(2, 8'hA5);
    rd_chk(2, 8'h00, "R8 rx write ignored");
    rd_chk(12, 8'h00, "R8 hole 12 reads zero");
    rd_chk(30, 8'h00, "R8 hole 30 reads zero");
  endtask

  task automatic run_sf(input int s, input bit frc, input int wr_f, input int wr_a,
                        input logic [7:0] wr_d);
    bit pv = 0;
    logic er = 0, et = 0;
    bit rsig = 0;
    force_ones = frc;
    for (int f = 0; f < 24; f++)
      for (int c = 0; c < 24; c++)
        for (int b = 0; b < 8; b++) begin
          bit sg;
          int l;
          @(negedge clk);
          if (pv) begin
            chk(8'(rx_out), 8'(er), (rsig && frc) ? "R3 forced robbed bit" : "R2 rx passthrough");
            chk(8'(tx_out), 8'(et), rsig ? "R5 R7 tx inserted bit" : "R6 tx passthrough");
          end
          if (f % 6 == 5 && c == 12 && b == 0) chk_rx_regs("R4 mid-frame old value");
          if (f % 6 == 0 && f > 0 && c == 0 && b == 0) chk_rx_regs("R4 after frame commit");
          sg = (f % 6 == 5) && (b == 7);
          l = f / 6;
          frame_num = 5'(f); chan_idx = 5'(c); bit_idx = 3'(b);
          rx_data = sg ? sv(s, c, l) : db(s, f, c, b);
          tx_in = ~db(s + 1, f, c, b);
          er = (sg && frc) ? 1'b1 : rx_data;
          et = sg ? act[c / 2][bpos(c, l)] : tx_in;
          rsig = sg;
          pv = 1;
          cpu_wr = (f == wr_f && c == 0 && b == 0);
          if (cpu_wr) begin
            cpu_addr = 5'(wr_a); cpu_wdata = wr_d; shd[wr_a - 16] = wr_d;
          end
          if (sg && c == 23)
            for (int cc = 0; cc < 24; cc++) exp_rx[cc][l] = sv(s, cc, l);
        end
    @(negedge clk);
    chk(8'(rx_out), 8'(er), "R2 R3 last bit");
    chk(8'(tx_out), 8'(et), "R5 last bit");
    frame_num = '0; chan_idx = '0; bit_idx = '0; cpu_wr = 1'b0; rx_data = 1'b0;
    for (int k = 0; k < 12; k++) act[k] = shd[k];
    chk_rx_regs("R1 rx regs end of superframe");
  endtask

  initial begin
    for (int k = 0; k < 12; k++) begin shd[k] = '0; act[k] = '0; end
    for (int c = 0; c < 24; c++) for (int l = 0; l < 4; l++) exp_rx[c][l] = 0;
    test_reset();
    test_cpu_access();
    run_sf(0, 1'b0, -1, 16, 8'h00);
    run_sf(1, 1'b1, 11, 18, 8'h5A);
    rd_chk(18, 8'h5A, "R10 mid-superframe write readback");
    run_sf(2, 1'b0, -1, 16, 8'h00);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule